// File: doc/BRIEF.md
# SDRAM Command and Address Decoder

This block sits on the device side of an SDRAM command bus. On every rising clock edge it samples the per-rank active-low chip selects, the three command strobes (row strobe, column strobe, write enable), the bank-select bits and the address pins. It turns them into one registered operation strobe with its fields: the operation code, the rank, the bank, the row, the starting column, a burst-chop flag and an all-banks flag. The address pins are read differently for each command. On an activate they carry the row. On a read or write they carry the column, and bit 12 selects a chopped burst. On a precharge, bit 10 chooses between closing one bank and closing every bank of the rank.

For each rank the block keeps a table of eight bank state machines. Each bank machine has two named states: `BK_IDLE` (precharged, no row held) and `BK_OPEN` (a row is latched). The transition `BK_IDLE -> BK_OPEN` is taken on an accepted activate addressed to that bank. The transition `BK_OPEN -> BK_IDLE` is taken on a precharge that targets that bank, either directly or through the all-banks flag. Every other case keeps the current state. The tables are visible on the ports as a per-bank open flag and a per-bank row. Commands that break bank state, or that select more than one rank at once, raise a one-cycle error pulse and are discarded.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, `dec_op` is 0 (none), `dec_err` is 0, every field output is 0, and every bank of every rank is idle, with its row reading 0.
- R2: When every chip select is high, the sampled command is ignored. No operation, no error and no bank-state change results.
- R3: With exactly one chip select low, the pins {ras_n,cas_n,we_n} decode as follows: 011 is activate, 101 is read, 100 is write, 010 is precharge. Every other code, including 111, produces `dec_op`=0 and no error. The `dec_op` codes are: 0 none, 1 activate, 2 read, 3 write, 4 precharge.
- R4: A command sampled at rising edge k appears on the decoded outputs, and in the bank status, from edge k until edge k+1. Commands may arrive on back-to-back cycles, and each one sees the bank state left by the previous one.
- R5: An activate to an idle bank opens it and stores `addr[13:0]` as its row. The outputs report the rank, the bank from `ba[2:0]` and that row.
- R6: A read or write to an open bank reports the column from `addr[9:0]`, the chop flag from `addr[12]` (1 = 4-beat chop, 0 = 8-beat burst) and the bank's open row. Bank state is unchanged.
- R7: A precharge with `addr[10]`=0 closes only the bank `ba` of the selected rank. With `addr[10]`=1 it closes all eight banks of that rank. `dec_all` reports `addr[10]`. A precharge to an idle bank is legal.
- R8: A read or write to an idle bank, or an activate to an open bank, drives `dec_err` high for one cycle with `dec_op`=0 and leaves every bank unchanged.
- R9: When more than one chip select is low, `dec_err` is 1, `dec_op` is 0 and no bank changes, whatever the command pins carry.
- R10: Each rank has its own bank table. A command for one rank never changes the state or the rows of another rank.
- R11: Field outputs that do not apply read 0. `dec_col` and `dec_chop` are 0 except on read or write. `dec_all` is 0 except on precharge. `dec_row` is 0 on precharge and none. `dec_rank` and `dec_bank` are 0 on none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | RANKS (2) | Active-low chip select, one per rank |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| ba | input | BANK_W (3) | Bank select |
| addr | input | ADDR_W (14) | Multiplexed address pins |
| dec_op | output | 3 | Decoded operation code |
| dec_rank | output | RANK_W (1) | Rank of the decoded operation |
| dec_bank | output | BANK_W (3) | Bank of the decoded operation |
| dec_row | output | ROW_W (14) | Row opened, or row being accessed |
| dec_col | output | COL_W (10) | Starting column of a read or write |
| dec_chop | output | 1 | Burst-chop request on read or write |
| dec_all | output | 1 | All-banks precharge |
| dec_err | output | 1 | One-cycle illegal-command pulse |
| bank_open | output | RANKS*BANKS (16) | Open flag, bit rank*BANKS+bank |
| bank_row | output | RANKS*BANKS*ROW_W (224) | Open row, slice (rank*BANKS+bank)*ROW_W |

## Verification
Error detection and the bank-table update are judged in the same cycle on the same command. An activate that would be legal for its bank but arrives with both chip selects low, and an activate that carries a new row to a bank that is already open, must both raise the error and leave the stored row as it was. The bench provokes both cases on purpose, then runs a long random mix of chip selects, command codes, banks and addresses so that collisions occur often. A behavioural model built from the requirements predicts every output and the whole flattened bank status, and compares them on every clock. A write that slipped through alongside an error therefore shows up as a row mismatch in that same cycle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // decoded operation codes seen on dec_op
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4
    } op_e;

    // pin patterns on {ras_n, cas_n, we_n}
    localparam logic [2:0] PINS_ACT = 3'b011;
    localparam logic [2:0] PINS_RD  = 3'b101;
    localparam logic [2:0] PINS_WR  = 3'b100;
    localparam logic [2:0] PINS_PRE = 3'b010;

    // per-bank machine states
    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_OPEN = 1'b1
    } bank_st_e;

endpackage

// File: rtl/sdcmd_bank_fsm.sv
module sdcmd_bank_fsm
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_out
);

    bank_st_e st_q, st_d;
    logic [ROW_W-1:0] row_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_IDLE: if (open_req)  st_d = BK_OPEN;
            BK_OPEN: if (close_req) st_d = BK_IDLE;
        endcase
    end

    // latched row, cleared when the bank closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (st_q == BK_IDLE && open_req) begin
            row_q <= row_in;
        end else if (st_q == BK_OPEN && close_req) begin
            row_q <= '0;
        end
    end

    // outputs
    always_comb begin
        is_open = (st_q == BK_OPEN);
        row_out = row_q;
    end

endmodule

// File: rtl/sdcmd_rank_table.sv
module sdcmd_rank_table
    import sdcmd_pkg::*;
#(
    parameter int BANKS  = 8,
    parameter int ROW_W  = 14,
    parameter int BANK_W = $clog2(BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_go,
    input  logic                   pre_go,
    input  logic                   pre_all,
    input  logic [BANK_W-1:0]      bank,
    input  logic [ROW_W-1:0]       row,
    output logic                   hit_open,
    output logic [ROW_W-1:0]       hit_row,
    output logic [BANKS-1:0]       open_vec,
    output logic [BANKS*ROW_W-1:0] row_flat
);

    logic [ROW_W-1:0] rows [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic sel_b;
        assign sel_b = (bank == BANK_W'(b));

        sdcmd_bank_fsm #(
            .ROW_W (ROW_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (act_go && sel_b),
            .close_req (pre_go && (pre_all || sel_b)),
            .row_in    (row),
            .is_open   (open_vec[b]),
            .row_out   (rows[b])
        );

        assign row_flat[b*ROW_W +: ROW_W] = rows[b];
    end

    always_comb begin
        hit_open = open_vec[bank];
        hit_row  = rows[bank];
    end

endmodule

// File: rtl/sdcmd_pin_decode.sv
module sdcmd_pin_decode
    import sdcmd_pkg::*;
#(
    parameter int RANKS  = 2,
    parameter int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
    input  logic [RANKS-1:0]  cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    output logic              one_sel,
    output logic              multi_sel,
    output logic [RANK_W-1:0] rank_idx,
    output op_e               cmd
);

    always_comb begin
        one_sel   = ($countones(~cs_n) == 1);
        multi_sel = ($countones(~cs_n) > 1);
        rank_idx  = '0;
        for (int r = 0; r < RANKS; r++) begin
            if (!cs_n[r]) rank_idx = RANK_W'(r);
        end
    end

    always_comb begin
        case ({ras_n, cas_n, we_n})
            PINS_ACT: cmd = OP_ACT;
            PINS_RD:  cmd = OP_RD;
            PINS_WR:  cmd = OP_WR;
            PINS_PRE: cmd = OP_PRE;
            default:  cmd = OP_NONE;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
    import sdcmd_pkg::*;
#(
    parameter int RANKS    = 2,
    parameter int BANKS    = 8,
    parameter int ROW_W    = 14,
    parameter int COL_W    = 10,
    parameter int ADDR_W   = 14,
    parameter int CHOP_BIT = 12,
    parameter int ALL_BIT  = 10,
    localparam int BANK_W  = $clog2(BANKS),
    localparam int RANK_W  = (RANKS > 1) ? $clog2(RANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [RANKS-1:0]             cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [BANK_W-1:0]            ba,
    input  logic [ADDR_W-1:0]            addr,
    output logic [2:0]                   dec_op,
    output logic [RANK_W-1:0]            dec_rank,
    output logic [BANK_W-1:0]            dec_bank,
    output logic [ROW_W-1:0]             dec_row,
    output logic [COL_W-1:0]             dec_col,
    output logic                         dec_chop,
    output logic                         dec_all,
    output logic                         dec_err,
    output logic [RANKS*BANKS-1:0]       bank_open,
    output logic [RANKS*BANKS*ROW_W-1:0] bank_row
);

    // ---------------- pin decode ----------------
    logic              one_sel, multi_sel;
    logic [RANK_W-1:0] rank_idx;
    op_e               cmd;

    sdcmd_pin_decode #(
        .RANKS  (RANKS),
        .RANK_W (RANK_W)
    ) u_pins (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .one_sel   (one_sel),
        .multi_sel (multi_sel),
        .rank_idx  (rank_idx),
        .cmd       (cmd)
    );

    // ---------------- legality ----------------
    logic [RANKS-1:0] hit_open_v;
    logic [ROW_W-1:0] hit_row_a [RANKS];
    logic             hit_open;
    logic [ROW_W-1:0] hit_row;
    logic             is_rw;
    logic             act_go, rw_go, pre_go, bad;

    always_comb begin
        hit_open = hit_open_v[rank_idx];
        hit_row  = hit_row_a[rank_idx];
        is_rw    = (cmd == OP_RD) || (cmd == OP_WR);
        act_go   = one_sel && (cmd == OP_ACT) && !hit_open;
        rw_go    = one_sel && is_rw && hit_open;
        pre_go   = one_sel && (cmd == OP_PRE);
        bad      = multi_sel ||
                   (one_sel && (((cmd == OP_ACT) && hit_open) ||
                                (is_rw && !hit_open)));
    end

    // ---------------- per-rank bank tables ----------------
    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        logic mine;
        assign mine = (rank_idx == RANK_W'(r));

        sdcmd_rank_table #(
            .BANKS  (BANKS),
            .ROW_W  (ROW_W),
            .BANK_W (BANK_W)
        ) u_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_go   (act_go && mine),
            .pre_go   (pre_go && mine),
            .pre_all  (addr[ALL_BIT]),
            .bank     (ba),
            .row      (addr[ROW_W-1:0]),
            .hit_open (hit_open_v[r]),
            .hit_row  (hit_row_a[r]),
            .open_vec (bank_open[r*BANKS +: BANKS]),
            .row_flat (bank_row[r*BANKS*ROW_W +: BANKS*ROW_W])
        );
    end

    // ---------------- next decoded outputs ----------------
    op_e               op_d, op_q;
    logic [RANK_W-1:0] rank_d, rank_q;
    logic [BANK_W-1:0] bank_d, bank_q;
    logic [ROW_W-1:0]  row_d, row_q;
    logic [COL_W-1:0]  col_d, col_q;
    logic              chop_d, chop_q;
    logic              all_d, all_q;
    logic              err_q;

    always_comb begin
        op_d   = OP_NONE;
        rank_d = '0;
        bank_d = '0;
        row_d  = '0;
        col_d  = '0;
        chop_d = 1'b0;
        all_d  = 1'b0;
        if (act_go) begin
            op_d   = OP_ACT;
            rank_d = rank_idx;
            bank_d = ba;
            row_d  = addr[ROW_W-1:0];
        end else if (rw_go) begin
            op_d   = cmd;
            rank_d = rank_idx;
            bank_d = ba;
            row_d  = hit_row;
            col_d  = addr[COL_W-1:0];
            chop_d = addr[CHOP_BIT];
        end else if (pre_go) begin
            op_d   = OP_PRE;
            rank_d = rank_idx;
            bank_d = ba;
            all_d  = addr[ALL_BIT];
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            rank_q <= '0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            chop_q <= 1'b0;
            all_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            op_q   <= op_d;
            rank_q <= rank_d;
            bank_q <= bank_d;
            row_q  <= row_d;
            col_q  <= col_d;
            chop_q <= chop_d;
            all_q  <= all_d;
            err_q  <= bad;
        end
    end

    assign dec_op   = op_q;
    assign dec_rank = rank_q;
    assign dec_bank = bank_q;
    assign dec_row  = row_q;
    assign dec_col  = col_q;
    assign dec_chop = chop_q;
    assign dec_all  = all_q;
    assign dec_err  = err_q;

endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
    parameter int RANKS  = 2,
    parameter int BANKS  = 8,
    parameter int RANK_W = 1,
    parameter int BANK_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [RANKS-1:0]       cs_n,
    input logic [2:0]             dec_op,
    input logic [RANK_W-1:0]      dec_rank,
    input logic [BANK_W-1:0]      dec_bank,
    input logic                   dec_chop,
    input logic                   dec_all,
    input logic                   dec_err,
    input logic [RANKS*BANKS-1:0] bank_open
);

    logic addr_open;
    logic rank_any_open;

    always_comb begin
        addr_open     = bank_open[int'(dec_rank) * BANKS + int'(dec_bank)];
        rank_any_open = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            rank_any_open = rank_any_open | bank_open[int'(dec_rank) * BANKS + b];
        end
    end

    a_r2_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |=> (dec_op == 3'd0 && !dec_err && $stable(bank_open)));

    a_r5_act_leaves_open: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_op == 3'd1) |-> addr_open);

    a_r6_access_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_op == 3'd2 || dec_op == 3'd3) |-> addr_open);

    a_r7_all_banks_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_op == 3'd4 && dec_all) |-> !rank_any_open);

    a_r8_error_drops_op: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (dec_op == 3'd0));

    a_r9_multi_select_error: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~cs_n) > 1) |=> (dec_err && $stable(bank_open)));

    a_r11_chop_only_access: assert property (@(posedge clk) disable iff (!rst_n)
        dec_chop |-> (dec_op == 3'd2 || dec_op == 3'd3));

    a_r11_all_only_pre: assert property (@(posedge clk) disable iff (!rst_n)
        dec_all |-> (dec_op == 3'd4));

endmodule

bind sdram_cmd_decoder sdcmd_checker #(
    .RANKS  (RANKS),
    .BANKS  (BANKS),
    .RANK_W (RANK_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .dec_op    (dec_op),
    .dec_rank  (dec_rank),
    .dec_bank  (dec_bank),
    .dec_chop  (dec_chop),
    .dec_all   (dec_all),
    .dec_err   (dec_err),
    .bank_open (bank_open)
);

// File: tb/test_sdram_cmd_decoder.sv
`timescale 1ns/1ps
module test_sdram_cmd_decoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [1:0]   cs_n = 2'b11;
    logic         ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]   ba = '0;
    logic [13:0]  addr = '0;
    logic [2:0]   dec_op;
    logic         dec_rank;
    logic [2:0]   dec_bank;
    logic [13:0]  dec_row;
    logic [9:0]   dec_col;
    logic         dec_chop, dec_all, dec_err;
    logic [15:0]  bank_open;
    logic [223:0] bank_row;

    sdram_cmd_decoder i_sdram_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dec_op(dec_op), .dec_rank(dec_rank),
        .dec_bank(dec_bank), .dec_row(dec_row), .dec_col(dec_col),
        .dec_chop(dec_chop), .dec_all(dec_all), .dec_err(dec_err),
        .bank_open(bank_open), .bank_row(bank_row)
    );

    always #2.5 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string pend_tag = "R1";
    string cmp_tag = "R1";

    // reference model
    bit          m_open [2][8];
    logic [13:0] m_row  [2][8];
    logic [2:0]  e_op;
    logic        e_rank;
    logic [2:0]  e_bank;
    logic [13:0] e_row;
    logic [9:0]  e_col;
    logic        e_chop, e_all, e_err;

    always @(posedge clk or negedge rst_n) begin
        cmp_tag = pend_tag;
        e_op = 0; e_rank = 0; e_bank = 0; e_row = 0; e_col = 0;
        e_chop = 0; e_all = 0; e_err = 0;
        if (!rst_n) begin
            for (int r = 0; r < 2; r++)
                for (int b = 0; b < 8; b++) begin
                    m_open[r][b] = 0;
                    m_row[r][b]  = 0;
                end
        end else begin
            int nlow;
            int rk;
            nlow = (cs_n[0] == 1'b0) + (cs_n[1] == 1'b0);
            rk = cs_n[0] ? 1 : 0;
            if (nlow > 1) begin
                e_err = 1;
            end else if (nlow == 1) begin
                case ({ras_n, cas_n, we_n})
                    3'b011: begin
                        if (m_open[rk][ba]) e_err = 1;
                        else begin
                            m_open[rk][ba] = 1;
                            m_row[rk][ba]  = addr;
                            e_op = 1; e_rank = rk[0]; e_bank = ba; e_row = addr;
                        end
                    end
                    3'b101, 3'b100: begin
                        if (!m_open[rk][ba]) e_err = 1;
                        else begin
                            e_op = we_n ? 3'd2 : 3'd3;
                            e_rank = rk[0]; e_bank = ba;
                            e_row = m_row[rk][ba];
                            e_col = addr[9:0];
                            e_chop = addr[12];
                        end
                    end
                    3'b010: begin
                        e_op = 4; e_rank = rk[0]; e_bank = ba; e_all = addr[10];
                        for (int b = 0; b < 8; b++) begin
                            if (addr[10] || b == int'(ba)) begin
                                m_open[rk][b] = 0;
                                m_row[rk][b]  = 0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string nm, logic [255:0] act, logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cmp_tag, nm, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [15:0]  x_open;
            logic [223:0] x_row;
            for (int r = 0; r < 2; r++)
                for (int b = 0; b < 8; b++) begin
                    x_open[r*8+b]           = m_open[r][b];
                    x_row[(r*8+b)*14 +: 14] = m_row[r][b];
                end
            chk("op",        256'(dec_op),    256'(e_op));
            chk("err",       256'(dec_err),   256'(e_err));
            chk("rank",      256'(dec_rank),  256'(e_rank));
            chk("bank",      256'(dec_bank),  256'(e_bank));
            chk("row",       256'(dec_row),   256'(e_row));
            chk("col",       256'(dec_col),   256'(e_col));
            chk("chop",      256'(dec_chop),  256'(e_chop));
            chk("all",       256'(dec_all),   256'(e_all));
            chk("bank_open", 256'(bank_open), 256'(x_open));
            chk("bank_row",  256'(bank_row),  256'(x_row));
        end
    end

    task automatic issue(input logic [1:0] cs, input logic [2:0] pins,
                         input logic [2:0] b, input logic [13:0] a, input string t);
        @(negedge clk);
        cs_n = cs;
        {ras_n, cas_n, we_n} = pins;
        ba = b;
        addr = a;
        pend_tag = t;
    endtask

    task automatic idle(input int n, input string t);
        for (int i = 0; i < n; i++) issue(2'b11, 3'b111, 3'd0, 14'd0, t);
    endtask

    localparam logic [1:0] RK0 = 2'b10, RK1 = 2'b01, NONE = 2'b11, BOTH = 2'b00;
    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_NOP = 3'b111;

    initial begin
        #1 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;                               // R1 reset state compared while held
        idle(2, "R1");
        // R2: deselected activate is ignored
        issue(NONE, C_ACT, 3'd2, 14'h0123, "R2");
        issue(NONE, C_RD,  3'd2, 14'h0005, "R2");
        // R3: unknown codes and NOP decode to nothing
        issue(RK0, 3'b001, 3'd1, 14'h1111, "R3");
        issue(RK0, 3'b000, 3'd1, 14'h2222, "R3");
        issue(RK0, 3'b110, 3'd1, 14'h0400, "R3");
        issue(RK0, C_NOP,  3'd1, 14'h3333, "R3");
        // R5: activates, including max and zero rows
        issue(RK0, C_ACT, 3'd3, 14'h1234, "R5");
        issue(RK0, C_ACT, 3'd7, 14'h3FFF, "R5");
        issue(RK0, C_ACT, 3'd0, 14'h0000, "R5");
        // R4/R6: back-to-back activate then read in the next cycle
        issue(RK0, C_ACT, 3'd5, 14'h0ABC, "R4");
        issue(RK0, C_RD,  3'd5, 14'h1001, "R4");
        // R6: column, chop and ignored high bits
        issue(RK0, C_RD,  3'd3, 14'h13FF, "R6");
        issue(RK0, C_WR,  3'd7, 14'h2C05, "R6");
        issue(RK0, C_WR,  3'd0, 14'h1000, "R6");
        // R8: illegal accesses
        issue(RK0, C_RD,  3'd1, 14'h0007, "R8");
        issue(RK0, C_WR,  3'd6, 14'h0007, "R8");
        issue(RK0, C_ACT, 3'd3, 14'h0777, "R8");
        // R9: both ranks selected
        issue(BOTH, C_ACT, 3'd1, 14'h0042, "R9");
        issue(BOTH, C_NOP, 3'd1, 14'h0000, "R9");
        // R10: rank 1 independent of rank 0
        issue(RK1, C_ACT, 3'd3, 14'h0ABC, "R10");
        issue(RK1, C_RD,  3'd3, 14'h0010, "R10");
        issue(RK1, C_RD,  3'd7, 14'h0010, "R10");
        // R7: single-bank, idle-bank and all-bank precharge
        issue(RK0, C_PRE, 3'd3, 14'h0000, "R7");
        issue(RK0, C_PRE, 3'd3, 14'h1BFF, "R7");
        issue(RK0, C_PRE, 3'd1, 14'h0400, "R7");
        issue(RK0, C_RD,  3'd7, 14'h0000, "R7");
        issue(RK1, C_PRE, 3'd0, 14'h0400, "R7");
        idle(2, "R11");
        // R4 random mix of selects, codes, banks and addresses
        for (int i = 0; i < 3000; i++) begin
            int v;
            logic [1:0] cs;
            v = $urandom % 8;
            cs = (v < 3) ? RK0 : (v < 6) ? RK1 : (v == 6) ? NONE : BOTH;
            issue(cs, 3'($urandom), 3'($urandom), 14'($urandom), "R4 random");
        end
        idle(2, "R11");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule